// File: doc/BRIEF.md
# Banked Reservation Tracker

This block keeps the busy windows of the banks of a cache whose tag array and data array are banked and tracked separately. A controller that needs one or both arrays for an operation first asks whether the bank that serves its set index is free in each array it needs. The block answers with one flag per array and a combined grant. Asking has no side effects. Only when the grant is true does the controller commit its reservations, in that same cycle, on one or two commit ports. A request that needs both arrays therefore never holds one while it waits for the other, so two requests that want the arrays in opposite orders cannot block each other forever.

A committed reservation keeps the bank busy for `ACC_LAT` cycles, counted from the commit cycle. Within one cycle the two commit ports may name the same set, for example a read and a write of one set, and that counts as one reservation. Any other double booking of a bank raises an error flag that stays set until reset. A configuration input turns recording of reservations on or off. With `ACC_LAT` set to zero every bank is always free.

Top module: `bank_resv_tracker`

## Requirements
- R1: A check reports a bank free exactly when no reservation window covers the current cycle, and checks alone never change any later result.
- R2: A reservation committed in cycle t makes its bank report busy in cycles t+1 to t+ACC_LAT-1 and free from cycle t+ACC_LAT onward.
- R3: With ACC_LAT = 0 both free flags are always 1, the grant equals chk_valid, and the error flag never rises.
- R4: Two commits in one cycle to the same set in the same array are accepted as one reservation without error.
- R5: A commit to a bank that is still busy raises err_double on the next cycle and leaves the existing window unchanged. err_double stays 1 until reset.
- R6: Two commits in one cycle to one bank of one array with different set indices raise err_double. If the bank was free, the port A reservation is recorded.
- R7: chk_grant is 1 exactly when chk_valid is 1 and every array that chk_ops needs has a free bank for chk_set.
- R8: The op masks use bit 0 = tag read and bit 1 = tag write, which need the tag array, and bit 2 = data read and bit 3 = data write, which need the data array. The two arrays keep independent windows.
- R9: While cfg_stall_en is 0, commits are ignored: no window is recorded and no error is raised.
- R10: The bank of a set index is its low log2(BANKS) bits, so sets that differ only in higher bits share a window.
- R11: After reset every bank of both arrays is free and err_double is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_stall_en | input | 1 | Enables recording of reservations |
| chk_valid | input | 1 | A check request is present |
| chk_set | input | SET_W | Set index being checked |
| chk_ops | input | 4 | Operations the checked request needs |
| chk_tag_free | output | 1 | Tag bank for chk_set is free this cycle |
| chk_data_free | output | 1 | Data bank for chk_set is free this cycle |
| chk_grant | output | 1 | All needed banks are free |
| rsv_a_valid | input | 1 | Commit port A is active |
| rsv_a_set | input | SET_W | Set index for commit port A |
| rsv_a_ops | input | 4 | Operations committed on port A |
| rsv_b_valid | input | 1 | Commit port B is active |
| rsv_b_set | input | SET_W | Set index for commit port B |
| rsv_b_ops | input | 4 | Operations committed on port B |
| err_double | output | 1 | Sticky flag for an illegal double booking |

## Verification
A wrong end stamp shows up on the free flags as a bank that frees one or more cycles too early or too late. It is visible within ACC_LAT cycles of the commit. A wrong bank selection shows up as a busy window on a set that should not share it, or as a missing window on a set that should. Such faults are seen on the very next check of the affected set. Faults in the conflict logic show up on err_double one cycle after the commit that should, or should not, have raised it. Because the flag is sticky, a false error stays visible at every later check.

// File: rtl/bank_resv_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the banked reservation tracker.
// Assumes the op mask layout below is also used by the requesting controller.
package bank_resv_pkg;
    localparam int OP_W       = 4;
    localparam int OP_TAG_RD  = 0;
    localparam int OP_TAG_WR  = 1;
    localparam int OP_DATA_RD = 2;
    localparam int OP_DATA_WR = 3;
    localparam int N_ARR      = 2;
    localparam int ARR_TAG    = 0;
    localparam int ARR_DATA   = 1;

    typedef logic [OP_W-1:0]  op_mask_t;
    typedef logic [N_ARR-1:0] arr_need_t;
endpackage

// File: rtl/resv_op_decode.sv
`timescale 1ns/1ps
// Module: resv_op_decode
// Turns an op mask into the set of arrays the request needs.
// Assumes: the valid input qualifies the mask, so an invalid request needs nothing.
module resv_op_decode
    import bank_resv_pkg::*;
(
    input  logic      valid,
    input  op_mask_t  ops,
    output arr_need_t need
);
    // Purpose: tag ops need the tag array, data ops need the data array.
    always_comb begin
        need           = '0;
        need[ARR_TAG]  = valid && (ops[OP_TAG_RD] || ops[OP_TAG_WR]);
        need[ARR_DATA] = valid && (ops[OP_DATA_RD] || ops[OP_DATA_WR]);
    end
endmodule

// File: rtl/resv_cycle_counter.sv
`timescale 1ns/1ps
// Module: resv_cycle_counter
// Free-running cycle count that all busy windows are stamped against.
// Assumes: CNT_W is wide enough that the count does not wrap during operation.
module resv_cycle_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt
);
    // Purpose: count cycles since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cnt == $past(cnt) + 1'b1)); // R2
endmodule

// File: rtl/resv_bank_table.sv
`timescale 1ns/1ps
// Module: resv_bank_table
// Busy windows of every bank of one array. A check looks up one bank without
// side effects. Two commit ports may reserve in one cycle. The same set on both
// ports counts as one reservation. A busy bank, or two different sets on one
// bank, is reported as a conflict pulse. On a conflict, port A wins a free bank.
// Assumes: BANKS is a power of two, at least 2, and SET_W >= log2(BANKS).
module resv_bank_table #(
    parameter int SET_W   = 6,
    parameter int BANKS   = 4,
    parameter int ACC_LAT = 3,
    parameter int CNT_W   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [SET_W-1:0] chk_set,
    output logic             chk_free,
    input  logic             a_en,
    input  logic [SET_W-1:0] a_set,
    input  logic             b_en,
    input  logic [SET_W-1:0] b_set,
    output logic             conflict
);
    localparam int BSEL_W = $clog2(BANKS);

    generate
        if (ACC_LAT == 0) begin : g_nolat
            // Purpose: with zero latency the array never blocks.
            assign chk_free = 1'b1;
            assign conflict = 1'b0;
        end else begin : g_lat
            localparam logic [CNT_W-1:0] SPAN = CNT_W'(ACC_LAT - 1);
            localparam logic [CNT_W-1:0] LATV = CNT_W'(ACC_LAT);

            logic [BSEL_W-1:0] chk_bank, a_bank, b_bank;
            logic [BANKS-1:0]  busy, take, clash;
            logic              vld_q [BANKS];
            logic [CNT_W-1:0]  end_q [BANKS];

            assign chk_bank = chk_set[BSEL_W-1:0];
            assign a_bank   = a_set[BSEL_W-1:0];
            assign b_bank   = b_set[BSEL_W-1:0];

            for (genvar b = 0; b < BANKS; b++) begin : g_bank
                logic hit_a, hit_b;

                // Purpose: decode which commit ports land on this bank.
                assign hit_a = a_en && (a_bank == BSEL_W'(b));
                assign hit_b = b_en && (b_bank == BSEL_W'(b));

                // Purpose: bank is busy while its window reaches this cycle.
                assign busy[b] = vld_q[b] && (end_q[b] >= cnt);

                // Purpose: a free bank accepts the reservation.
                assign take[b] = (hit_a || hit_b) && !busy[b];

                // Purpose: flag a busy bank or two different sets on one bank.
                assign clash[b] = ((hit_a || hit_b) && busy[b]) ||
                                  (hit_a && hit_b && (a_set != b_set));

                // Purpose: stamp the end of the window on an accepted reservation.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        vld_q[b] <= 1'b0;
                        end_q[b] <= '0;
                    end else if (take[b]) begin
                        vld_q[b] <= 1'b1;
                        end_q[b] <= cnt + SPAN;
                    end
                end

                AST_WINDOW_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
                    take[b] |=> (busy[b] || (ACC_LAT == 1))); // R2
                AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
                    busy[b] |-> ((end_q[b] - cnt) < LATV)); // R2
                AST_BUSY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
                    busy[b] |=> $stable(end_q[b])); // R5
                AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
                    (!a_en && !b_en) |=> ($stable(vld_q[b]) && $stable(end_q[b]))); // R9
            end

            // Purpose: answer a check from the selected bank without side effects.
            assign chk_free = !busy[chk_bank];
            // Purpose: any clash in this cycle is a double booking.
            assign conflict = |clash;
        end
    endgenerate
endmodule

// File: rtl/bank_resv_tracker.sv
`timescale 1ns/1ps
// Module: bank_resv_tracker (top)
// Two-phase reservation tracker for a cache with banked tag and data arrays.
// A check reports free flags and a grant. Commits reserve banks. A double
// booking sets a sticky error flag.
// Assumes: the controller commits only in a cycle in which its check was granted.
module bank_resv_tracker
    import bank_resv_pkg::*;
#(
    parameter int SET_W   = 6,
    parameter int BANKS   = 4,
    parameter int ACC_LAT = 3,
    parameter int CNT_W   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_stall_en,
    input  logic             chk_valid,
    input  logic [SET_W-1:0] chk_set,
    input  logic [OP_W-1:0]  chk_ops,
    output logic             chk_tag_free,
    output logic             chk_data_free,
    output logic             chk_grant,
    input  logic             rsv_a_valid,
    input  logic [SET_W-1:0] rsv_a_set,
    input  logic [OP_W-1:0]  rsv_a_ops,
    input  logic             rsv_b_valid,
    input  logic [SET_W-1:0] rsv_b_set,
    input  logic [OP_W-1:0]  rsv_b_ops,
    output logic             err_double
);
    logic [CNT_W-1:0] cnt;
    arr_need_t        chk_need, a_need, b_need, arr_free, arr_clash;
    logic             a_live, b_live;

    resv_cycle_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .cnt(cnt)
    );

    // Purpose: commits count only while reservation recording is enabled.
    assign a_live = rsv_a_valid && cfg_stall_en;
    assign b_live = rsv_b_valid && cfg_stall_en;

    resv_op_decode u_dec_chk (.valid(chk_valid), .ops(chk_ops),   .need(chk_need));
    resv_op_decode u_dec_a   (.valid(a_live),    .ops(rsv_a_ops), .need(a_need));
    resv_op_decode u_dec_b   (.valid(b_live),    .ops(rsv_b_ops), .need(b_need));

    generate
        for (genvar x = 0; x < N_ARR; x++) begin : g_arr
            resv_bank_table #(
                .SET_W(SET_W), .BANKS(BANKS), .ACC_LAT(ACC_LAT), .CNT_W(CNT_W)
            ) u_tab (
                .clk(clk), .rst_n(rst_n), .cnt(cnt),
                .chk_set(chk_set), .chk_free(arr_free[x]),
                .a_en(a_need[x]), .a_set(rsv_a_set),
                .b_en(b_need[x]), .b_set(rsv_b_set),
                .conflict(arr_clash[x])
            );
        end
    endgenerate

    // Purpose: expose per-array availability and the combined grant.
    assign chk_tag_free  = arr_free[ARR_TAG];
    assign chk_data_free = arr_free[ARR_DATA];
    assign chk_grant     = chk_valid && ((chk_need & ~arr_free) == '0);

    // Purpose: hold any double booking until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)          err_double <= 1'b0;
        else if (|arr_clash) err_double <= 1'b1;
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_double |=> err_double); // R5
    AST_GRANT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        chk_grant |-> chk_valid); // R7
    AST_OFF_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_stall_en |=> (err_double == $past(err_double))); // R9
    AST_ZERO_LAT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (ACC_LAT == 0) |-> (chk_tag_free && chk_data_free && !err_double)); // R3
endmodule

// File: tb/sim_bank_resv_tracker.sv
`timescale 1ns/1ps
module sim_bank_resv_tracker;
    localparam int SW  = 4;
    localparam int NB  = 4;
    localparam int LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          d_en, d_cv, d_av, d_bv;
    logic [SW-1:0] d_cset, d_aset, d_bset;
    logic [3:0]    d_cops, d_aops, d_bops;
    logic          tf0, df0, g0, e0, tf1, df1, g1, e1;

    bank_resv_tracker #(.SET_W(SW), .BANKS(NB), .ACC_LAT(LAT), .CNT_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_stall_en(d_en),
        .chk_valid(d_cv), .chk_set(d_cset), .chk_ops(d_cops),
        .chk_tag_free(tf0), .chk_data_free(df0), .chk_grant(g0),
        .rsv_a_valid(d_av), .rsv_a_set(d_aset), .rsv_a_ops(d_aops),
        .rsv_b_valid(d_bv), .rsv_b_set(d_bset), .rsv_b_ops(d_bops),
        .err_double(e0));

    bank_resv_tracker #(.SET_W(SW), .BANKS(NB), .ACC_LAT(0), .CNT_W(32)) u1 (
        .clk(clk), .rst_n(rst_n), .cfg_stall_en(d_en),
        .chk_valid(d_cv), .chk_set(d_cset), .chk_ops(d_cops),
        .chk_tag_free(tf1), .chk_data_free(df1), .chk_grant(g1),
        .rsv_a_valid(d_av), .rsv_a_set(d_aset), .rsv_a_ops(d_aops),
        .rsv_b_valid(d_bv), .rsv_b_set(d_bset), .rsv_b_ops(d_bops),
        .err_double(e1));

    int  n_chk = 0;
    int  n_err = 0;
    int  rem [2][NB];
    bit  m_err;
    bit  done = 0;

    task automatic expect_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit needs(input logic [3:0] ops, input int x);
        return (x == 0) ? (ops[0] | ops[1]) : (ops[2] | ops[3]);
    endfunction

    task automatic clear_model();
        for (int x = 0; x < 2; x++) for (int b = 0; b < NB; b++) rem[x][b] = 0;
        m_err = 0;
    endtask

    task automatic idle_inputs();
        d_cv = 0; d_cset = '0; d_cops = '0;
        d_av = 0; d_aset = '0; d_aops = '0;
        d_bv = 0; d_bset = '0; d_bops = '0;
    endtask

    // One cycle: drive check inputs, compare availability, optionally auto-commit
    // on port A when the model grants, then update the model over the edge.
    task automatic run(input string req, input bit auto_a);
        bit exp_t, exp_d, exp_g, e;
        bit tk [2][NB];
        int cb, ba, bb;
        @(negedge clk);
        #1;
        cb    = int'(d_cset) % NB;
        exp_t = (rem[0][cb] == 0);
        exp_d = (rem[1][cb] == 0);
        exp_g = d_cv && (!needs(d_cops, 0) || exp_t) && (!needs(d_cops, 1) || exp_d);
        expect_eq(req, "tag_free", int'(tf0), int'(exp_t));
        expect_eq(req, "data_free", int'(df0), int'(exp_d));
        expect_eq({req, " R7"}, "grant", int'(g0), int'(exp_g));
        expect_eq("R3", "zero-lat tag_free", int'(tf1), 1);
        expect_eq("R3", "zero-lat data_free", int'(df1), 1);
        expect_eq("R3", "zero-lat grant", int'(g1), int'(d_cv));
        if (auto_a) begin
            d_av = exp_g; d_aset = d_cset; d_aops = d_cops;
        end
        e = 0;
        ba = int'(d_aset) % NB;
        bb = int'(d_bset) % NB;
        for (int x = 0; x < 2; x++) begin
            bit na, nb;
            for (int b = 0; b < NB; b++) tk[x][b] = 0;
            na = d_av && d_en && needs(d_aops, x);
            nb = d_bv && d_en && needs(d_bops, x);
            if (na && rem[x][ba] > 0) e = 1;
            if (nb && rem[x][bb] > 0) e = 1;
            if (na && nb && ba == bb && d_aset != d_bset) e = 1;
            if (na && rem[x][ba] == 0) tk[x][ba] = 1;
            if (nb && rem[x][bb] == 0) tk[x][bb] = 1;
        end
        @(posedge clk);
        for (int x = 0; x < 2; x++) for (int b = 0; b < NB; b++) begin
            if (rem[x][b] > 0) rem[x][b]--;
            if (tk[x][b]) rem[x][b] = LAT - 1;
        end
        m_err = m_err | e;
        #1;
        expect_eq({req, " R5"}, "err_double", int'(e0), int'(m_err));
        expect_eq("R3", "zero-lat err", int'(e1), 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        idle_inputs();
        d_en = 1;
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
        clear_model();
    endtask

    task automatic check_only(input logic [SW-1:0] s, input logic [3:0] ops, input string req);
        idle_inputs();
        d_cv = 1; d_cset = s; d_cops = ops;
        run(req, 0);
    endtask

    task automatic commit_a(input logic [SW-1:0] s, input logic [3:0] ops, input string req);
        idle_inputs();
        d_cv = 1; d_cset = s; d_cops = ops;
        d_av = 1; d_aset = s; d_aops = ops;
        run(req, 0);
    endtask

    initial begin
        logic [15:0] lf;
        idle_inputs();
        d_en = 1;
        clear_model();
        do_reset();

        // R11 / R1: every set free in both arrays after reset, checks have no effect
        for (int s = 0; s < 16; s++) check_only(SW'(s), 4'b1111, "R11");
        expect_eq("R11", "err after reset", int'(e0), 0);

        // R2 / R10 / R8: tag window on set 5 (bank 1), seen through set 9
        commit_a(4'd5, 4'b0001, "R2");
        check_only(4'd9, 4'b0001, "R10");
        check_only(4'd5, 4'b0100, "R8");
        check_only(4'd6, 4'b0010, "R10");
        check_only(4'd13, 4'b1000, "R2");

        // R4: both ports, same set, tag read and tag write in one cycle
        idle_inputs();
        d_cv = 1; d_cset = 4'd7; d_cops = 4'b0011;
        d_av = 1; d_aset = 4'd7; d_aops = 4'b0001;
        d_bv = 1; d_bset = 4'd7; d_bops = 4'b0010;
        run("R4", 0);
        check_only(4'd7, 4'b0011, "R4");

        // R9: recording disabled, commits ignored
        d_en = 0;
        commit_a(4'd2, 4'b1111, "R9");
        commit_a(4'd2, 4'b1111, "R9");
        check_only(4'd2, 4'b1111, "R9");
        d_en = 1;

        // R1: repeated checks leave set 2 free
        for (int i = 0; i < 4; i++) check_only(4'd2, 4'b1111, "R1");

        // sweep: checks over all sets and op masks, commits only on grant
        lf = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            idle_inputs();
            d_en   = (lf[3:0] != 4'h0);
            d_cv   = (lf[2:0] != 3'h0);
            d_cset = lf[7:4];
            d_cops = lf[11:8];
            d_bv   = lf[0] && d_cv;
            d_bset = lf[7:4];
            d_bops = lf[11:8] & lf[15:12];
            if (!(d_cv && (!needs(d_cops, 0) || rem[0][int'(d_cset) % NB] == 0) &&
                  (!needs(d_cops, 1) || rem[1][int'(d_cset) % NB] == 0))) d_bv = 0;
            run("R7", 1);
        end
        d_en = 1;

        // R5: commit to a busy bank raises a sticky error, window unchanged
        do_reset();
        commit_a(4'd3, 4'b0100, "R5");
        commit_a(4'd3, 4'b1000, "R5");
        check_only(4'd3, 4'b0100, "R5");
        check_only(4'd3, 4'b0100, "R5");
        for (int i = 0; i < 3; i++) check_only(4'd0, 4'b0000, "R5");

        // R6: two sets on one bank in the same cycle, port A recorded
        do_reset();
        idle_inputs();
        d_cv = 1; d_cset = 4'd1; d_cops = 4'b0001;
        d_av = 1; d_aset = 4'd1; d_aops = 4'b0001;
        d_bv = 1; d_bset = 4'd5; d_bops = 4'b0010;
        run("R6", 0);
        check_only(4'd9, 4'b0001, "R6");
        check_only(4'd1, 4'b0001, "R6");
        check_only(4'd1, 4'b0001, "R6");

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule